// File: doc/BRIEF.md
# Integer ALU with Local Function Decode

This block is the arithmetic and logic engine of a small 32-bit load/store processor. The main controller hands it a compact operation class and, for register-register instructions, the unit resolves the instruction's 6-bit function field itself. The result is a 32-bit value plus a flag that is high whenever that value is zero; branch logic uses the flag to decide equal or not-equal.

The unit adds, subtracts, performs AND, OR and NOR, produces a signed set-on-less-than, and shifts logically in either direction. The shifts run through a tree of 2-to-1 multiplexers, one level per shift-amount bit. Right shifts pass through the same tree, with the data bit-reversed before and after it. The value shifted is the second operand (the rt register), and the distance comes from the instruction's shift-amount field. Arithmetic wraps silently: no overflow trap is raised.

The block is purely combinational and has no clock. Its outputs follow its inputs within the same cycle, so no handshake applies. The surrounding datapath registers the result wherever its own timing requires.

Top module: `alu_unit`

## Requirements
- R1: With class 3'b000 the result is A+B, whatever the function field holds.
- R2: With class 3'b001 the result is A-B, whatever the function field holds.
- R3: Class 3'b011 gives A AND B and class 3'b100 gives A OR B, whatever the function field holds.
- R4: With class 3'b010 the function field selects the operation: 6'b100000 add, 6'b100010 subtract, 6'b100100 AND, 6'b100101 OR, 6'b100111 NOR.
- R5: With class 3'b010 and function 6'b101010 the result is 1 when A is below B as signed 32-bit numbers, and 0 otherwise. This holds at the most negative and most positive values.
- R6: With class 3'b010 and function 6'b000000 the result is B shifted left by the shift amount, with zeros filling in.
- R7: With class 3'b010 and function 6'b000010 the result is B shifted right logically by the shift amount, with zeros filling in.
- R8: A shift amount of 0 returns B unchanged in both directions, and an amount of 31 keeps exactly one bit of B.
- R9: Function 6'b001000 under class 3'b010, any other function code not listed, and classes 3'b101 to 3'b111 all return A unchanged.
- R10: The zero output is 1 exactly when the result is all zeros.
- R11: Addition and subtraction wrap modulo 2^32 and raise no other indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 3 | Operation class from the main controller |
| funct | input | 6 | Instruction function field |
| shamt | input | 5 | Shift distance from the instruction |
| opnd_a | input | 32 | First operand (rs) |
| opnd_b | input | 32 | Second operand (rt or immediate) |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench goes after signed comparison at the extremes, such as the most negative value against a positive one. A design that took the raw sign of the difference would report the wrong order there. It runs every shift distance from 0 to 31 in both directions. A wrongly wired multiplexer level, or a missing bit reversal, would drop bits or pull in ones at one particular distance. It also drives misleading function codes under the fixed classes and unlisted codes under the decoded class. A decoder that looked at the field too eagerly would return the wrong operation instead of the sum or operand A. Finally, the zero flag is checked on results that cancel to zero and on results that are nonzero in only their top bit.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  typedef enum logic [2:0] {
    CLS_ADD   = 3'b000,
    CLS_SUB   = 3'b001,
    CLS_FUNC  = 3'b010,
    CLS_ANDI  = 3'b011,
    CLS_ORI   = 3'b100
  } alu_class_e;

  typedef enum logic [5:0] {
    FN_SLL = 6'b000000,
    FN_SRL = 6'b000010,
    FN_JR  = 6'b001000,
    FN_ADD = 6'b100000,
    FN_SUB = 6'b100010,
    FN_AND = 6'b100100,
    FN_OR  = 6'b100101,
    FN_NOR = 6'b100111,
    FN_SLT = 6'b101010
  } alu_funct_e;

  typedef enum logic [3:0] {
    OP_PASSA,
    OP_ADD,
    OP_SUB,
    OP_AND,
    OP_OR,
    OP_NOR,
    OP_SLT,
    OP_SLL,
    OP_SRL
  } alu_op_e;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [2:0] op_class,
  input  logic [5:0] funct,
  output alu_op_e    op
);
  alu_op_e fn_op;

  always_comb begin
    unique case (funct)
      FN_ADD:  fn_op = OP_ADD;
      FN_SUB:  fn_op = OP_SUB;
      FN_AND:  fn_op = OP_AND;
      FN_OR:   fn_op = OP_OR;
      FN_NOR:  fn_op = OP_NOR;
      FN_SLT:  fn_op = OP_SLT;
      FN_SLL:  fn_op = OP_SLL;
      FN_SRL:  fn_op = OP_SRL;
      default: fn_op = OP_PASSA;
    endcase
  end

  always_comb begin
    unique case (op_class)
      CLS_ADD:  op = OP_ADD;
      CLS_SUB:  op = OP_SUB;
      CLS_FUNC: op = fn_op;
      CLS_ANDI: op = OP_AND;
      CLS_ORI:  op = OP_OR;
      default:  op = OP_PASSA;
    endcase
  end

  // jump-register code must never select a computing operation
  always_comb begin
    if (op_class == CLS_FUNC && funct == FN_JR)
      assert_jr_passes_R9: assert (op == OP_PASSA);
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amount,
  input  logic             go_right,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] din_rev;
  logic [WIDTH-1:0] tree_in;
  logic [WIDTH-1:0] tree_out;
  logic [WIDTH-1:0] tree_rev;
  logic [WIDTH-1:0] level [AMT_W+1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign din_rev[i]  = din[WIDTH-1-i];
    assign tree_rev[i] = tree_out[WIDTH-1-i];
  end

  assign tree_in  = go_right ? din_rev : din;
  assign level[0] = tree_in;

  for (genvar k = 0; k < AMT_W; k++) begin : g_level
    localparam int unsigned STEP = 1 << k;
    assign level[k+1] = amount[k]
      ? {level[k][WIDTH-1-STEP:0], {STEP{1'b0}}}
      : level[k];
  end

  assign tree_out = level[AMT_W];
  assign dout     = go_right ? tree_rev : tree_out;

  always_comb begin
    if (amount == '0)
      assert_zero_shift_R8: assert (dout == din);
    if (amount != '0 && !go_right)
      assert_left_fill_R6: assert (dout[0] == 1'b0);
    if (amount != '0 && go_right)
      assert_right_fill_R7: assert (dout[WIDTH-1] == 1'b0);
  end
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             less
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;
  logic             ovf;

  assign b_eff = subtract ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
  assign sum   = full[WIDTH-1:0];
  assign ovf   = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
  assign less  = sum[WIDTH-1] ^ ovf;

  always_comb begin
    if (subtract)
      assert_sub_inverse_R11: assert (sum + b == a);
    else
      assert_add_inverse_R11: assert (sum - b == a);
    if (subtract)
      assert_signed_order_R5: assert (less == ($signed(a) < $signed(b)));
  end
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
(
  input  logic [2:0]         op_class,
  input  logic [5:0]         funct,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [DATA_W-1:0]  opnd_a,
  input  logic [DATA_W-1:0]  opnd_b,
  output logic [DATA_W-1:0]  result,
  output logic               zero
);
  alu_op_e           op;
  logic [DATA_W-1:0] arith_sum;
  logic              arith_less;
  logic [DATA_W-1:0] shifted;
  logic              use_sub;

  alu_decode u_decode (
    .op_class (op_class),
    .funct    (funct),
    .op       (op)
  );

  assign use_sub = (op == OP_SUB) || (op == OP_SLT);

  alu_arith #(.WIDTH(DATA_W)) u_arith (
    .a        (opnd_a),
    .b        (opnd_b),
    .subtract (use_sub),
    .sum      (arith_sum),
    .less     (arith_less)
  );

  alu_shifter #(.WIDTH(DATA_W)) u_shift (
    .din      (opnd_b),
    .amount   (shamt),
    .go_right (op == OP_SRL),
    .dout     (shifted)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result = arith_sum;
      OP_AND:         result = opnd_a & opnd_b;
      OP_OR:          result = opnd_a | opnd_b;
      OP_NOR:         result = ~(opnd_a | opnd_b);
      OP_SLT:         result = {{(DATA_W-1){1'b0}}, arith_less};
      OP_SLL, OP_SRL: result = shifted;
      default:        result = opnd_a;
    endcase
  end

  assign zero = ~|result;

  always_comb begin
    if (op_class == CLS_ADD)
      assert_fixed_add_R1: assert (result == opnd_a + opnd_b);
    if (op_class == CLS_SUB)
      assert_fixed_sub_R2: assert (result == opnd_a - opnd_b);
    if (op_class == CLS_ANDI)
      assert_fixed_and_R3: assert (result == (opnd_a & opnd_b));
    if (op_class == CLS_ORI)
      assert_fixed_or_R3: assert (result == (opnd_a | opnd_b));
    if (op_class == CLS_FUNC && funct == FN_NOR)
      assert_nor_R4: assert ((result & (opnd_a | opnd_b)) == '0);
    if (op_class == CLS_FUNC && funct == FN_SLT)
      assert_slt_narrow_R5: assert (result[DATA_W-1:1] == '0);
    if (op_class == CLS_FUNC && funct == FN_SLL)
      assert_sll_R6: assert (result == (opnd_b << shamt));
    if (op_class == CLS_FUNC && funct == FN_SRL)
      assert_srl_R7: assert (result == (opnd_b >> shamt));
    if (op_class > CLS_ORI)
      assert_spare_class_R9: assert (result == opnd_a);
    assert_zero_flag_R10: assert (zero == (result == '0));
  end
endmodule

// File: tb/alu_unit_tb.sv
module alu_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_class;
  logic [5:0]  funct;
  logic [4:0]  shamt;
  logic [31:0] opnd_a, opnd_b;
  logic [31:0] result;
  logic        zero;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [31:0] vals [12];

  always #2.5 clk = ~clk;

  alu_unit u_dut (
    .op_class (op_class), .funct (funct), .shamt (shamt),
    .opnd_a (opnd_a), .opnd_b (opnd_b), .result (result), .zero (zero)
  );

  task automatic apply(input logic [2:0] c, input logic [5:0] f,
                       input logic [4:0] s, input logic [31:0] a,
                       input logic [31:0] b);
    @(posedge clk);
    op_class = c; funct = f; shamt = s; opnd_a = a; opnd_b = b;
    @(negedge clk);
  endtask

  task automatic expect_res(input string req, input logic [31:0] exp);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s class=%b funct=%b shamt=%0d a=%h b=%h result=%h expected=%h",
               req, op_class, funct, shamt, opnd_a, opnd_b, result, exp);
    end
    checks++;
    if (zero !== (exp == 32'd0)) begin
      errors++;
      $display("FAIL R10 zero=%b expected=%b for result %h", zero, exp == 32'd0, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
             32'h8000_0001, 32'h7FFF_FFFE, 32'h1234_5678, 32'hDEAD_BEEF,
             32'h0000_FFFF, 32'hFFFF_0000, 32'h5555_AAAA};
    op_class = 3'b000; funct = 6'b0; shamt = 5'd0; opnd_a = 32'd0; opnd_b = 32'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // initial state: all-zero inputs give zero result with flag set (R10)
    @(negedge clk);
    expect_res("R10", 32'd0);

    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        logic [31:0] a, b;
        a = vals[i]; b = vals[j];
        // fixed classes with misleading function fields
        apply(3'b000, 6'b100010, 5'd3, a, b); expect_res("R1 R11", a + b);
        apply(3'b001, 6'b100000, 5'd7, a, b); expect_res("R2 R11", a - b);
        apply(3'b011, 6'b100101, 5'd1, a, b); expect_res("R3", a & b);
        apply(3'b100, 6'b100100, 5'd1, a, b); expect_res("R3", a | b);
        // decoded class
        apply(3'b010, 6'b100000, 5'd0, a, b); expect_res("R4", a + b);
        apply(3'b010, 6'b100010, 5'd0, a, b); expect_res("R4", a - b);
        apply(3'b010, 6'b100100, 5'd0, a, b); expect_res("R4", a & b);
        apply(3'b010, 6'b100101, 5'd0, a, b); expect_res("R4", a | b);
        apply(3'b010, 6'b100111, 5'd0, a, b); expect_res("R4", ~(a | b));
        apply(3'b010, 6'b101010, 5'd0, a, b);
        expect_res("R5", ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
        // pass-through cases
        apply(3'b010, 6'b001000, 5'd4, a, b); expect_res("R9", a);
        apply(3'b010, 6'b111111, 5'd4, a, b); expect_res("R9", a);
        apply(3'b101 + 3'(j % 3), 6'b100000, 5'd4, a, b); expect_res("R9", a);
      end
    end

    for (int i = 0; i < 12; i++) begin
      for (int s = 0; s < 32; s++) begin
        logic [31:0] b, p;
        b = vals[i];
        p = 32'd1 << s;
        apply(3'b010, 6'b000000, 5'(s), 32'hCAFE_F00D, b);
        expect_res((s == 0 || s == 31) ? "R6 R8" : "R6", b * p);
        apply(3'b010, 6'b000010, 5'(s), 32'hCAFE_F00D, b);
        expect_res((s == 0 || s == 31) ? "R7 R8" : "R7", b / p);
      end
    end

    // zero flag when only the top bit is set, and on exact cancellation
    apply(3'b001, 6'b0, 5'd0, 32'h8000_0000, 32'h0); expect_res("R10", 32'h8000_0000);
    apply(3'b000, 6'b0, 5'd0, 32'hFFFF_FFFF, 32'h1); expect_res("R10 R11", 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule